// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It supports register-to-register add, subtract, and, or and signed set-less-than, or with an immediate, word load, word store, branch on equality and an absolute jump. The program counter logic, the decoder, a 32-entry register file, the immediate extender, the ALU and the writeback selection are all inside one module. Instruction and data storage are word arrays held inside the core. A testbench or a loader fills the instruction array before reset is released.

Register file reads and memory reads are combinational. The only state that changes at the rising clock edge is the program counter, the register file and the data array. A set of debug taps shows the address of the instruction now executing and the register write it will commit at the next edge. Those taps are the only outputs, so all results are observed through them.

Top module: `sc_core`

## Requirements
- R1: While reset is high, the PC is cleared to zero and all 32 registers are cleared to zero. After reset is released, the first instruction executed is the word at address 0.
- R2: Encodings use op = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, funct = 5:0, imm = 15:0 and target = 25:0. Every instruction that is neither a branch nor a jump advances the PC by 4, one instruction per cycle.
- R3: For op 0x00, funct 0x20, 0x22, 0x24 and 0x25 write rs+rt, rs-rt, rs AND rt and rs OR rt into rd. An unknown funct writes nothing.
- R4: For op 0x00 with funct 0x2A, rd receives 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Op 0x0D writes rs OR the zero-extended imm into rt.
- R6: Op 0x23 loads the data word at address rs + sign-extended imm into rt. The array is indexed by the address bits just above bit 1.
- R7: Op 0x2B stores rt at address rs + sign-extended imm at the clock edge and writes no register.
- R8: Op 0x04 compares rs and rt. When they are equal the next PC is PC+4+(sign-extended imm × 4); otherwise it is PC+4. It writes no register.
- R9: Op 0x02 sets the next PC to the top four bits of PC+4, followed by target, followed by two zero bits.
- R10: Register 0 always reads as zero. A write aimed at it is shown on the debug tap but leaves its value unchanged.
- R11: An instruction that names its destination as a source reads the value the register held before this cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates at the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_rf_we | output | 1 | Current instruction requests a register write |
| dbg_rf_waddr | output | 5 | Destination register of that write |
| dbg_rf_wdata | output | 32 | Value to be written at the next edge |

## Verification
Two functions share a cycle in this core: the combinational register read that feeds the ALU, and the register write committed at the end of that cycle. The bench runs chains such as doubling a register into itself. Each step must show the sum of the old values, which proves the read sees the pre-edge contents and the write lands exactly once per cycle. A store followed at once by a load from the same address puts a data write and a data read on neighbouring edges. That pair is judged by the loaded value shown on the write tap.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_rf_we,
  output logic [4:0]  dbg_rf_waddr,
  output logic [31:0] dbg_rf_wdata
);
  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [2:0] ALU_ADD = 3'd0;
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_AND = 3'd2;
  localparam logic [2:0] ALU_OR  = 3'd3;
  localparam logic [2:0] ALU_SLT = 3'd4;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  initial for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;

  logic [31:0] pc, pc_next, pc_plus4;
  logic [31:0] instr;

  assign instr = imem[pc[IA_W+1:2]];

  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  logic [25:0] tgt;
  logic        unused_shamt;

  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign imm   = instr[15:0];
  assign tgt   = instr[25:0];
  assign unused_shamt = ^instr[10:6];

  logic       reg_dst, alu_src, zero_ext, mem_to_reg, reg_write, mem_write;
  logic       is_branch, is_jump;
  logic [2:0] alu_ctl;

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    zero_ext   = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_write  = 1'b0;
    is_branch  = 1'b0;
    is_jump    = 1'b0;
    alu_ctl    = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        reg_dst = 1'b1;
        reg_write = 1'b1;
        unique case (funct)
          FN_ADD: alu_ctl = ALU_ADD;
          FN_SUB: alu_ctl = ALU_SUB;
          FN_AND: alu_ctl = ALU_AND;
          FN_OR:  alu_ctl = ALU_OR;
          FN_SLT: alu_ctl = ALU_SLT;
          default: reg_write = 1'b0;
        endcase
      end
      OP_ORI: begin
        alu_src = 1'b1;
        zero_ext = 1'b1;
        alu_ctl = ALU_OR;
        reg_write = 1'b1;
      end
      OP_LW: begin
        alu_src = 1'b1;
        mem_to_reg = 1'b1;
        reg_write = 1'b1;
      end
      OP_SW: begin
        alu_src = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        alu_ctl = ALU_SUB;
        is_branch = 1'b1;
      end
      OP_J: is_jump = 1'b1;
      default: ;
    endcase
  end

  logic [31:0] rs_val, rt_val, ext_imm, alu_b, alu_y, mem_rd, wb_data;
  logic [4:0]  wb_addr;
  logic        alu_zero;

  assign rs_val  = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val  = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign ext_imm = zero_ext ? {16'd0, imm} : {{16{imm[15]}}, imm};
  assign alu_b   = alu_src ? ext_imm : rt_val;

  always_comb begin
    unique case (alu_ctl)
      ALU_SUB: alu_y = rs_val - alu_b;
      ALU_AND: alu_y = rs_val & alu_b;
      ALU_OR:  alu_y = rs_val | alu_b;
      ALU_SLT: alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_y = rs_val + alu_b;
    endcase
  end

  assign alu_zero = (alu_y == 32'd0);
  assign mem_rd   = dmem[alu_y[DA_W+1:2]];
  assign wb_data  = mem_to_reg ? mem_rd : alu_y;
  assign wb_addr  = reg_dst ? rd : rt;

  assign pc_plus4 = pc + 32'd4;

  always_comb begin
    if (is_jump)
      pc_next = {pc_plus4[31:28], tgt, 2'b00};
    else if (is_branch && alu_zero)
      pc_next = pc_plus4 + {{14{imm[15]}}, imm, 2'b00};
    else
      pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (reg_write && wb_addr != 5'd0) begin
      rf[wb_addr] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && mem_write) dmem[alu_y[DA_W+1:2]] <= rt_val;
  end

  assign dbg_pc       = pc;
  assign dbg_rf_we    = reg_write;
  assign dbg_rf_waddr = wb_addr;
  assign dbg_rf_wdata = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  op,
  input logic [15:0] imm,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        we,
  input logic [31:0] r0
);
  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04 && op != 6'h02) |=> pc == $past(pc) + 32'd4);

  assert_store_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    op == 6'h2B |-> !we);

  assert_beq_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00});

  assert_beq_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    op == 6'h04 |-> !we);

  assert_r0_zero_R10: assert property (@(posedge clk) disable iff (rst)
    r0 == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .op(op), .imm(imm),
  .rs_val(rs_val), .rt_val(rt_val), .we(dbg_rf_we), .r0(rf[0])
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_rf_we;
  logic [4:0]  dbg_rf_waddr;
  logic [31:0] dbg_rf_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we),
    .dbg_rf_waddr(dbg_rf_waddr), .dbg_rf_wdata(dbg_rf_wdata)
  );

  function automatic logic [31:0] rtype(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] o, input int s, input int t, input logic [15:0] i);
    return {o, 5'(s), 5'(t), i};
  endfunction
  function automatic logic [31:0] jtype(input logic [25:0] t);
    return {6'h02, t};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk); #5;
  endtask

  task automatic wr(input string req, input int a, input logic [31:0] d);
    chk({req, " we"}, 32'(dbg_rf_we), 32'd1);
    chk({req, " addr"}, 32'(dbg_rf_waddr), 32'(a));
    chk({req, " data"}, dbg_rf_wdata, d);
    adv();
  endtask

  task automatic boot(input logic [31:0] prog[]);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) u_sc_core.imem[i] = 32'd0;
    foreach (prog[i]) u_sc_core.imem[i] = prog[i];
    adv(); adv();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    boot('{itype(6'h0D, 0, 1, 16'h0005), rtype(1, 1, 2, 6'h20)});
    wr("R1 pre", 1, 32'h5);
    wr("R1 pre", 2, 32'hA);
    boot('{rtype(1, 2, 3, 6'h20)});
    chk("R1 pc", dbg_pc, 32'd0);
    wr("R1 regs cleared", 3, 32'd0);
  endtask

  task automatic t_alu();
    boot('{itype(6'h0D, 0, 1, 16'h0F0F), itype(6'h0D, 0, 2, 16'h00FF),
           rtype(1, 2, 3, 6'h20), rtype(2, 1, 4, 6'h22), rtype(1, 2, 5, 6'h24),
           rtype(1, 2, 6, 6'h25), itype(6'h0D, 0, 7, 16'h8000), rtype(1, 2, 8, 6'h3F)});
    wr("R5 ori", 1, 32'h0F0F);
    chk("R2 pc seq", dbg_pc, 32'd4);
    wr("R5 ori", 2, 32'h00FF);
    wr("R3 add", 3, 32'h100E);
    wr("R3 sub", 4, 32'hFFFFF1F0);
    wr("R3 and", 5, 32'h000F);
    wr("R3 or", 6, 32'h0FFF);
    wr("R5 zero-ext", 7, 32'h00008000);
    chk("R3 unknown funct", 32'(dbg_rf_we), 32'd0);
    chk("R2 pc seq", dbg_pc, 32'd28);
  endtask

  task automatic t_slt();
    boot('{itype(6'h0D, 0, 1, 16'hFFFF), rtype(0, 1, 2, 6'h22),
           rtype(2, 1, 3, 6'h2A), rtype(1, 2, 4, 6'h2A), rtype(1, 1, 5, 6'h2A)});
    wr("R4 setup", 1, 32'h0000FFFF);
    wr("R4 setup", 2, 32'hFFFF0001);
    wr("R4 neg<pos", 3, 32'd1);
    wr("R4 pos<neg", 4, 32'd0);
    wr("R4 equal", 5, 32'd0);
  endtask

  task automatic t_mem();
    boot('{itype(6'h0D, 0, 1, 16'h0040), itype(6'h0D, 0, 2, 16'h1234),
           itype(6'h2B, 1, 2, 16'h0008), itype(6'h23, 1, 3, 16'h0008),
           itype(6'h0D, 0, 4, 16'h0050), itype(6'h23, 4, 5, 16'hFFF8)});
    wr("R6 setup", 1, 32'h40);
    wr("R7 setup", 2, 32'h1234);
    chk("R7 store no reg write", 32'(dbg_rf_we), 32'd0);
    adv();
    wr("R6 load after store", 3, 32'h1234);
    wr("R6 setup", 4, 32'h50);
    wr("R6 negative offset", 5, 32'h1234);
  endtask

  task automatic t_branch();
    boot('{itype(6'h0D, 0, 1, 16'd7), itype(6'h0D, 0, 2, 16'd7),
           itype(6'h04, 1, 2, 16'd2), itype(6'h0D, 0, 9, 16'd1),
           itype(6'h0D, 0, 9, 16'd1), itype(6'h04, 1, 0, 16'd5),
           itype(6'h04, 0, 0, 16'hFFF9)});
    adv(); adv();
    chk("R8 at beq", dbg_pc, 32'd8);
    chk("R8 beq no write", 32'(dbg_rf_we), 32'd0);
    adv();
    chk("R8 taken", dbg_pc, 32'd20);
    adv();
    chk("R8 not taken", dbg_pc, 32'd24);
    adv();
    chk("R8 backward", dbg_pc, 32'd0);
  endtask

  task automatic t_jump();
    logic [31:0] p[6];
    foreach (p[i]) p[i] = 32'd0;
    p[0] = jtype(26'd5);
    p[5] = itype(6'h0D, 0, 1, 16'd1);
    boot(p);
    adv();
    chk("R9 jump target", dbg_pc, 32'd20);
    wr("R9 after jump", 1, 32'd1);
  endtask

  task automatic t_r0();
    boot('{itype(6'h0D, 0, 0, 16'h0055), rtype(0, 0, 1, 6'h25)});
    wr("R10 tap shows r0 write", 0, 32'h55);
    wr("R10 r0 reads zero", 1, 32'd0);
  endtask

  task automatic t_same_cycle();
    boot('{itype(6'h0D, 0, 1, 16'd3), rtype(1, 1, 1, 6'h20), rtype(1, 1, 1, 6'h20),
           rtype(1, 1, 1, 6'h22)});
    wr("R11 setup", 1, 32'd3);
    wr("R11 self add", 1, 32'd6);
    wr("R11 self add", 1, 32'd12);
    wr("R11 self sub", 1, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_alu();
    t_slt();
    t_mem();
    t_branch();
    t_jump();
    t_r0();
    t_same_cycle();
    finish_run();
  end
endmodule